// File: doc/BRIEF.md
# Accumulator Shift, Rotate and Arithmetic Unit

This unit carries out one single-word operation per transfer on a 16-bit accumulator value. Each transfer delivers an instruction word, a source operand, the present accumulator value and the four status flags: carry, sign, zero and overflow. The unit decodes the instruction and produces the new accumulator value and the new flags. Each operation rewrites only its own subset of the flags and carries the others through unchanged. The operations cover bitwise logic with a source operand, complement and negate, arithmetic shifts by one, two or four places, a logical right shift, rotates with and without the carry, byte and nibble swaps, and add and subtract with or without the incoming carry. Reading the register file, choosing the source operand and fetching instructions are left to the surrounding datapath.

Operands enter through a valid/ready input port. Results leave through a valid/ready output port that has one register stage. An operand set transfers on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented on the next cycle. A presented result stays unchanged until the consumer takes it with `out_ready`. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so back-pressure from the consumer reaches the producer combinationally and no result is dropped or duplicated.

Top module: `acc_alu`

## Requirements
- R1: An input transfer (in_valid and in_ready high at a rising edge) makes out_valid high on the next cycle. While out_valid is high and out_ready low, out_acc and all output flags hold their values, and in_ready is low. Results leave in the order their inputs were accepted.
- R2: After reset, out_valid is low, out_acc is zero, all output flags are zero, and in_ready is high.
- R3: An accumulator-only instruction has instr[15:12]=1000, instr[11:8]=1010 and instr[3:0]=1010. Its nibble instr[7:4] selects the operation: 0001 complement, 1001 negate, 0010/0011/0110 shift left by 1/2/4, 0100 rotate left, 0101 rotate left through carry, 1111/1110/1011 arithmetic shift right by 1/2/4, 1010 logical shift right, 1100 rotate right, 1101 rotate right through carry, 1000 byte swap, 0111 nibble swap within each byte.
- R4: A source instruction has instr[11:8]=1010 and a non-zero code in instr[14:12]: 001 AND, 010 OR, 011 XOR, 100 add, 110 add with carry, 101 subtract, 111 subtract with borrow. instr[15] and instr[7:0] do not affect the result.
- R5: AND, OR, XOR, complement (~acc) and negate (~acc+1) update only the sign flag (the result's bit 15) and the zero flag (set when all result bits are 0). Carry and overflow pass through unchanged.
- R6: A left shift by n fills the low bits with 0. Carry takes acc[16-n], the last bit shifted out. Sign and zero are updated and overflow is kept.
- R7: An arithmetic right shift by n fills the high bits with acc[15]. Carry takes acc[n-1]. Zero is updated, and sign and overflow are kept.
- R8: The logical right shift fills bit 15 with 0. Carry takes acc[0]. Sign and zero are updated.
- R9: A plain rotate (left or right) moves the end bit to the other end and updates only sign. A rotate through carry shifts the old carry in, loads carry from the bit shifted out, and updates sign and zero.
- R10: Byte swap exchanges the two bytes. Nibble swap exchanges the two nibbles inside each byte. Both update only sign.
- R11: Add computes acc+src and add with carry computes acc+src+carry. Carry is the carry out of bit 15. Overflow is set when acc and src have the same sign and the result's sign differs from acc's sign. Sign and zero are updated.
- R12: Subtract computes acc-src and subtract with borrow computes acc-(src+carry). Carry is set when the unsigned acc is less than src plus the incoming carry. Overflow is set when acc and src differ in sign and the result's sign differs from acc's sign. Sign and zero are updated.
- R13: Any other instruction word returns the input accumulator and all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operand set is offered |
| in_ready | output | 1 | Unit can take an operand set |
| in_instr | input | 16 | Instruction word |
| in_src | input | 16 | Source operand |
| in_acc | input | 16 | Present accumulator value |
| in_carry | input | 1 | Present carry flag |
| in_sign | input | 1 | Present sign flag |
| in_zero | input | 1 | Present zero flag |
| in_ovf | input | 1 | Present overflow flag |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result |
| out_acc | output | 16 | New accumulator value |
| out_carry | output | 1 | New carry flag |
| out_sign | output | 1 | New sign flag |
| out_zero | output | 1 | New zero flag |
| out_ovf | output | 1 | New overflow flag |

## Verification
Two things can happen on the same edge: the consumer takes a held result, and a new operand set is captured into the same output register. The bench provokes this by driving out_ready randomly, about three cycles in four, while it streams back-to-back operations. In many cycles the register is therefore emptied and refilled at one edge, and in others it is held under back-pressure. The scoreboard judges this by requiring each popped result to match its queued model value in order. It also requires any result that was held under back-pressure to be unchanged in the following cycle. A lost, duplicated or corrupted result shows up as a mismatch or as a non-empty queue at the end.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [4:0] {
    OP_PASS, OP_AND, OP_OR, OP_XOR,
    OP_ADD, OP_ADDC, OP_SUB, OP_SUBB,
    OP_CPL, OP_NEG,
    OP_SLA1, OP_SLA2, OP_SLA4,
    OP_RL, OP_RLC,
    OP_SRA1, OP_SRA2, OP_SRA4,
    OP_SR, OP_RR, OP_RRC,
    OP_XCH, OP_XCHN
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic sign;
    logic carry;
  } alu_flags_t;

  localparam int unsigned INSTR_W = 16;
  localparam logic [3:0] GROUP_CODE  = 4'b1010;
  localparam logic [3:0] UNARY_HI    = 4'b1000;
  localparam logic [3:0] UNARY_LO    = 4'b1010;

  function automatic logic uses_adder(alu_op_e op);
    return op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBB};
  endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output alu_op_e            op
);

  logic [2:0] src_code;
  logic [3:0] sel_nib;
  logic       grp_hit;
  logic       unary_hit;

  assign src_code  = instr[14:12];
  assign sel_nib   = instr[7:4];
  assign grp_hit   = (instr[11:8] == GROUP_CODE);
  assign unary_hit = grp_hit && (instr[15:12] == UNARY_HI) && (instr[3:0] == UNARY_LO);

  always_comb begin
    op = OP_PASS;
    if (grp_hit && (src_code != 3'b000)) begin
      unique case (src_code)
        3'b001:  op = OP_AND;
        3'b010:  op = OP_OR;
        3'b011:  op = OP_XOR;
        3'b100:  op = OP_ADD;
        3'b110:  op = OP_ADDC;
        3'b101:  op = OP_SUB;
        3'b111:  op = OP_SUBB;
        default: op = OP_PASS;
      endcase
    end else if (unary_hit) begin
      case (sel_nib)
        4'b0001: op = OP_CPL;
        4'b1001: op = OP_NEG;
        4'b0010: op = OP_SLA1;
        4'b0011: op = OP_SLA2;
        4'b0110: op = OP_SLA4;
        4'b0100: op = OP_RL;
        4'b0101: op = OP_RLC;
        4'b1111: op = OP_SRA1;
        4'b1110: op = OP_SRA2;
        4'b1011: op = OP_SRA4;
        4'b1010: op = OP_SR;
        4'b1100: op = OP_RR;
        4'b1101: op = OP_RRC;
        4'b1000: op = OP_XCH;
        4'b0111: op = OP_XCHN;
        default: op = OP_PASS;
      endcase
    end
  end

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] src,
  input  alu_flags_t        flags_in,
  output logic [DATA_W-1:0] res,
  output alu_flags_t        flags_out
);

  localparam int unsigned HALF  = DATA_W / 2;
  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned MSB   = DATA_W - 1;

  logic [DATA_W-1:0] byte_sw;
  logic [DATA_W-1:0] nib_sw;
  logic              upd_s;
  logic              upd_z;

  assign byte_sw = {acc[HALF-1:0], acc[MSB:HALF]};

  for (genvar b = 0; b < BYTES; b++) begin : g_nib
    assign nib_sw[8*b +: 8] = {acc[8*b +: 4], acc[8*b+4 +: 4]};
  end

  always_comb begin
    res       = acc;
    flags_out = flags_in;
    upd_s     = 1'b0;
    upd_z     = 1'b0;
    case (op)
      OP_AND:  begin res = acc & src; upd_s = 1'b1; upd_z = 1'b1; end
      OP_OR:   begin res = acc | src; upd_s = 1'b1; upd_z = 1'b1; end
      OP_XOR:  begin res = acc ^ src; upd_s = 1'b1; upd_z = 1'b1; end
      OP_CPL:  begin res = ~acc;      upd_s = 1'b1; upd_z = 1'b1; end
      OP_NEG:  begin res = ~acc + {{(DATA_W-1){1'b0}}, 1'b1}; upd_s = 1'b1; upd_z = 1'b1; end
      OP_SLA1: begin
        res = acc << 1; flags_out.carry = acc[DATA_W-1]; upd_s = 1'b1; upd_z = 1'b1;
      end
      OP_SLA2: begin
        res = acc << 2; flags_out.carry = acc[DATA_W-2]; upd_s = 1'b1; upd_z = 1'b1;
      end
      OP_SLA4: begin
        res = acc << 4; flags_out.carry = acc[DATA_W-4]; upd_s = 1'b1; upd_z = 1'b1;
      end
      OP_RL:   begin res = {acc[MSB-1:0], acc[MSB]}; upd_s = 1'b1; end
      OP_RLC:  begin
        res = {acc[MSB-1:0], flags_in.carry}; flags_out.carry = acc[MSB];
        upd_s = 1'b1; upd_z = 1'b1;
      end
      OP_SRA1: begin res = {{1{acc[MSB]}}, acc[MSB:1]}; flags_out.carry = acc[0]; upd_z = 1'b1; end
      OP_SRA2: begin res = {{2{acc[MSB]}}, acc[MSB:2]}; flags_out.carry = acc[1]; upd_z = 1'b1; end
      OP_SRA4: begin res = {{4{acc[MSB]}}, acc[MSB:4]}; flags_out.carry = acc[3]; upd_z = 1'b1; end
      OP_SR:   begin
        res = {1'b0, acc[MSB:1]}; flags_out.carry = acc[0]; upd_s = 1'b1; upd_z = 1'b1;
      end
      OP_RR:   begin res = {acc[0], acc[MSB:1]}; upd_s = 1'b1; end
      OP_RRC:  begin
        res = {flags_in.carry, acc[MSB:1]}; flags_out.carry = acc[0];
        upd_s = 1'b1; upd_z = 1'b1;
      end
      OP_XCH:  begin res = byte_sw; upd_s = 1'b1; end
      OP_XCHN: begin res = nib_sw;  upd_s = 1'b1; end
      default: ;
    endcase
    if (upd_s) flags_out.sign = res[MSB];
    if (upd_z) flags_out.zero = (res == '0);
  end

endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] src,
  input  alu_flags_t        flags_in,
  output logic [DATA_W-1:0] res,
  output alu_flags_t        flags_out
);

  localparam int unsigned EXT_W = DATA_W + 1;
  localparam int unsigned MSB   = DATA_W - 1;

  logic             cin;
  logic             is_sub;
  logic [EXT_W-1:0] sum_x;
  logic [EXT_W-1:0] dif_x;
  logic             same_sign;

  assign cin       = ((op == OP_ADDC) || (op == OP_SUBB)) ? flags_in.carry : 1'b0;
  assign is_sub    = (op == OP_SUB) || (op == OP_SUBB);
  assign sum_x     = {1'b0, acc} + {1'b0, src} + EXT_W'(cin);
  assign dif_x     = {1'b0, acc} - {1'b0, src} - EXT_W'(cin);
  assign same_sign = (acc[MSB] == src[MSB]);

  always_comb begin
    flags_out = flags_in;
    if (is_sub) begin
      res             = dif_x[DATA_W-1:0];
      flags_out.carry = dif_x[DATA_W];
      flags_out.ovf   = !same_sign && (res[MSB] != acc[MSB]);
    end else begin
      res             = sum_x[DATA_W-1:0];
      flags_out.carry = sum_x[DATA_W];
      flags_out.ovf   = same_sign && (res[MSB] != acc[MSB]);
    end
    flags_out.sign = res[MSB];
    flags_out.zero = (res == '0);
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_instr,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_acc,
  input  logic              in_carry,
  input  logic              in_sign,
  input  logic              in_zero,
  input  logic              in_ovf,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_acc,
  output logic              out_carry,
  output logic              out_sign,
  output logic              out_zero,
  output logic              out_ovf
);

  alu_op_e           op;
  alu_flags_t        flg_in;
  alu_flags_t        flg_bit;
  alu_flags_t        flg_arith;
  alu_flags_t        flg_next;
  alu_flags_t        flg_q;
  logic [DATA_W-1:0] res_bit;
  logic [DATA_W-1:0] res_arith;
  logic [DATA_W-1:0] res_next;
  logic [DATA_W-1:0] acc_q;
  logic              vld_q;
  logic              take;

  assign flg_in = '{ovf: in_ovf, zero: in_zero, sign: in_sign, carry: in_carry};

  acc_alu_decode u_dec (
    .instr (in_instr),
    .op    (op)
  );

  acc_alu_bitops #(.DATA_W(DATA_W)) u_bit (
    .op        (op),
    .acc       (in_acc),
    .src       (in_src),
    .flags_in  (flg_in),
    .res       (res_bit),
    .flags_out (flg_bit)
  );

  acc_alu_addsub #(.DATA_W(DATA_W)) u_arith (
    .op        (op),
    .acc       (in_acc),
    .src       (in_src),
    .flags_in  (flg_in),
    .res       (res_arith),
    .flags_out (flg_arith)
  );

  assign res_next = uses_adder(op) ? res_arith : res_bit;
  assign flg_next = uses_adder(op) ? flg_arith : flg_bit;

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= '0;
      flg_q <= '0;
    end else begin
      if (take) begin
        vld_q <= 1'b1;
        acc_q <= res_next;
        flg_q <= flg_next;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_acc   = acc_q;
  assign out_carry = flg_q.carry;
  assign out_sign  = flg_q.sign;
  assign out_zero  = flg_q.zero;
  assign out_ovf   = flg_q.ovf;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_acc) && $stable(flg_q)); // R1

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1

  AST_PASS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    take && (op == OP_PASS) |=> (out_acc == $past(in_acc)) && (flg_q == $past(flg_in))); // R13

  AST_SRA_KEEPS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    take && (op inside {OP_SRA1, OP_SRA2, OP_SRA4}) |=>
      (out_sign == $past(in_sign)) && (out_ovf == $past(in_ovf))); // R7

  AST_ROT_KEEPS_CZ: assert property (@(posedge clk) disable iff (!rst_n)
    take && (op inside {OP_RL, OP_RR}) |=>
      (out_carry == $past(in_carry)) && (out_zero == $past(in_zero))); // R9

  AST_SWAP_KEEPS_CZ: assert property (@(posedge clk) disable iff (!rst_n)
    take && (op inside {OP_XCH, OP_XCHN}) |=>
      (out_carry == $past(in_carry)) && (out_zero == $past(in_zero)) && (out_ovf == $past(in_ovf))); // R10

endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_instr;
  logic [15:0] in_src;
  logic [15:0] in_acc;
  logic        in_carry, in_sign, in_zero, in_ovf;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_acc;
  logic        out_carry, out_sign, out_zero, out_ovf;

  int checks;
  int errors;
  bit rand_ready;
  bit finished;

  logic [19:0] exp_q[$];
  string       tag_q[$];

  acc_alu uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_src(in_src), .in_acc(in_acc),
    .in_carry(in_carry), .in_sign(in_sign), .in_zero(in_zero), .in_ovf(in_ovf),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_acc(out_acc),
    .out_carry(out_carry), .out_sign(out_sign), .out_zero(out_zero), .out_ovf(out_ovf)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // result packing: {acc[15:0], ovf, zero, sign, carry}
  function automatic logic [19:0] model(input logic [15:0] ins, input logic [15:0] s16,
                                        input logic [15:0] a, input logic c, input logic s,
                                        input logic z, input logic o);
    logic [15:0] r;
    logic nc, ns, nz, no, us, uz;
    int t;
    r = a; nc = c; ns = s; nz = z; no = o; us = 1'b0; uz = 1'b0;
    if (ins[11:8] == 4'hA && ins[14:12] != 3'd0) begin
      us = 1'b1; uz = 1'b1;
      case (ins[14:12])
        3'd1: r = a & s16;
        3'd2: r = a | s16;
        3'd3: r = a ^ s16;
        3'd4, 3'd6: begin
          t = int'(a) + int'(s16) + ((ins[14:12] == 3'd6) ? int'(c) : 0);
          r = t[15:0]; nc = t[16];
          no = (a[15] == s16[15]) && (r[15] != a[15]);
        end
        default: begin
          t = int'(a) - int'(s16) - ((ins[14:12] == 3'd7) ? int'(c) : 0);
          r = t[15:0]; nc = (t < 0);
          no = (a[15] != s16[15]) && (r[15] != a[15]);
        end
      endcase
    end else if (ins[15:12] == 4'h8 && ins[11:8] == 4'hA && ins[3:0] == 4'hA) begin
      case (ins[7:4])
        4'h1: begin r = ~a; us = 1; uz = 1; end
        4'h9: begin r = ~a + 16'd1; us = 1; uz = 1; end
        4'h2: begin r = a << 1; nc = a[15]; us = 1; uz = 1; end
        4'h3: begin r = a << 2; nc = a[14]; us = 1; uz = 1; end
        4'h6: begin r = a << 4; nc = a[12]; us = 1; uz = 1; end
        4'h4: begin r = {a[14:0], a[15]}; us = 1; end
        4'h5: begin r = {a[14:0], c}; nc = a[15]; us = 1; uz = 1; end
        4'hF: begin r = {a[15], a[15:1]}; nc = a[0]; uz = 1; end
        4'hE: begin r = {{2{a[15]}}, a[15:2]}; nc = a[1]; uz = 1; end
        4'hB: begin r = {{4{a[15]}}, a[15:4]}; nc = a[3]; uz = 1; end
        4'hA: begin r = {1'b0, a[15:1]}; nc = a[0]; us = 1; uz = 1; end
        4'hC: begin r = {a[0], a[15:1]}; us = 1; end
        4'hD: begin r = {c, a[15:1]}; nc = a[0]; us = 1; uz = 1; end
        4'h8: begin r = {a[7:0], a[15:8]}; us = 1; end
        4'h7: begin r = {a[11:8], a[15:12], a[3:0], a[7:4]}; us = 1; end
        default: ;
      endcase
    end
    if (us) ns = r[15];
    if (uz) nz = (r == 16'h0000);
    return {r, no, nz, ns, nc};
  endfunction

  function automatic string tag_of(input logic [15:0] ins);
    if (ins[11:8] == 4'hA && ins[14:12] != 3'd0) begin
      case (ins[14:12])
        3'd4, 3'd6: return "R11";
        3'd5, 3'd7: return "R12";
        default:    return "R5";
      endcase
    end
    if (ins[15:12] == 4'h8 && ins[11:8] == 4'hA && ins[3:0] == 4'hA) begin
      case (ins[7:4])
        4'h1, 4'h9:       return "R5";
        4'h2, 4'h3, 4'h6: return "R6";
        4'hF, 4'hE, 4'hB: return "R7";
        4'hA:             return "R8";
        4'h4, 4'h5, 4'hC, 4'hD: return "R9";
        4'h8, 4'h7:       return "R10";
        default:          return "R13";
      endcase
    end
    return "R13";
  endfunction

  // driver: offers one operand set and queues its expected result
  task automatic send(input logic [15:0] ins, input logic [15:0] s16, input logic [15:0] a,
                      input logic [3:0] f, input string tag);
    @(negedge clk);
    in_instr = ins; in_src = s16; in_acc = a;
    {in_ovf, in_zero, in_sign, in_carry} = f;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(ins, s16, a, f[0], f[1], f[2], f[3]));
    tag_q.push_back(tag);
  endtask

  // back-pressure generator
  always @(posedge clk) begin
    #1;
    out_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  // monitor / scoreboard
  logic [19:0] held_val;
  bit          held;
  always @(negedge clk) begin
    logic [19:0] act;
    logic [19:0] exp;
    string tg;
    #2;
    act = {out_acc, out_ovf, out_zero, out_sign, out_carry};
    if (rst_n && held) begin
      chk(out_valid && act == held_val, "R1 hold under back-pressure", act, held_val);
    end
    held = 1'b0;
    if (rst_n && out_valid) begin
      if (out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected result", act, 20'h0);
        end else begin
          exp = exp_q.pop_front();
          tg  = tag_q.pop_front();
          chk(act == exp, tg, act, exp);
        end
      end else begin
        held = 1'b1;
        held_val = act;
        chk(!in_ready, "R1 in_ready low while stalled", {19'h0, in_ready}, 20'h0);
      end
    end
  end

  localparam int N_OPS = 22;
  logic [15:0] op_tab [N_OPS];

  initial begin
    op_tab[0]  = 16'h8A1A; op_tab[1]  = 16'h8A9A; op_tab[2]  = 16'h8A2A; op_tab[3]  = 16'h8A3A;
    op_tab[4]  = 16'h8A6A; op_tab[5]  = 16'h8A4A; op_tab[6]  = 16'h8A5A; op_tab[7]  = 16'h8AFA;
    op_tab[8]  = 16'h8AEA; op_tab[9]  = 16'h8ABA; op_tab[10] = 16'h8AAA; op_tab[11] = 16'h8ACA;
    op_tab[12] = 16'h8ADA; op_tab[13] = 16'h8A8A; op_tab[14] = 16'h8A7A; op_tab[15] = 16'h1A00;
    op_tab[16] = 16'h2A00; op_tab[17] = 16'h3A00; op_tab[18] = 16'h4A00; op_tab[19] = 16'h6A00;
    op_tab[20] = 16'h5A00; op_tab[21] = 16'h7A00;
  end

  initial begin
    checks = 0; errors = 0; rand_ready = 1'b0; finished = 1'b0; held = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_instr = '0; in_src = '0; in_acc = '0;
    in_carry = 0; in_sign = 0; in_zero = 0; in_ovf = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R2: reset state
    chk(!out_valid && in_ready, "R2 valid/ready after reset", {18'h0, out_valid, in_ready}, 20'h1);
    chk({out_acc, out_ovf, out_zero, out_sign, out_carry} == 20'h0, "R2 outputs after reset",
        {out_acc, out_ovf, out_zero, out_sign, out_carry}, 20'h0);

    // directed corner cases, flags as {ovf,zero,sign,carry}
    send(16'h1A00, 16'h0F0F, 16'h00FF, 4'b1001, "R5 AND keeps C/OV");
    send(16'h3A00, 16'hAAAA, 16'hAAAA, 4'b0000, "R5 XOR to zero");
    send(16'h8A9A, 16'h0000, 16'h0000, 4'b0000, "R5 NEG of zero");
    send(16'h8A9A, 16'h0000, 16'h8000, 4'b0000, "R5 NEG of min");
    send(16'h8A1A, 16'h0000, 16'h1234, 4'b1000, "R3 R5 CPL");
    send(16'h8A6A, 16'h0000, 16'h1F00, 4'b0000, "R6 SLA4 carry from bit12");
    send(16'h8A3A, 16'h0000, 16'h4001, 4'b1000, "R6 SLA2 carry from bit14");
    send(16'h8ABA, 16'h0000, 16'h8008, 4'b0000, "R7 SRA4 sign fill, carry bit3");
    send(16'h8AEA, 16'h0000, 16'h0002, 4'b0100, "R7 SRA2 keeps S, carry bit1");
    send(16'h8AAA, 16'h0000, 16'h8001, 4'b0100, "R8 SR zero fill");
    send(16'h8A4A, 16'h0000, 16'h8000, 4'b0010, "R9 RL only S");
    send(16'h8ADA, 16'h0000, 16'h0001, 4'b0001, "R9 RRC through carry");
    send(16'h8A5A, 16'h0000, 16'h8000, 4'b0000, "R9 RLC to zero");
    send(16'h8A8A, 16'h0000, 16'h00C3, 4'b0011, "R10 byte swap");
    send(16'h8A7A, 16'h0000, 16'h12F4, 4'b0010, "R10 nibble swap");
    send(16'h4A00, 16'h0001, 16'h7FFF, 4'b0000, "R11 ADD overflow");
    send(16'h6A00, 16'h0000, 16'hFFFF, 4'b0001, "R11 ADDC carry to zero");
    send(16'h6A00, 16'hFFFF, 16'h7FFF, 4'b0001, "R11 ADDC mixed signs");
    send(16'h5A00, 16'h0001, 16'h8000, 4'b0000, "R12 SUB overflow");
    send(16'h7A00, 16'hFFFF, 16'h0005, 4'b0001, "R12 SUBB borrow with full src");
    send(16'h5A00, 16'h0005, 16'h0005, 4'b0000, "R12 SUB equal");
    send(16'hDA37, 16'h0F0F, 16'h00FF, 4'b0000, "R4 bit15 and low byte ignored");
    send(16'h8A0A, 16'h1111, 16'h5A5A, 4'b1111, "R13 unused nibble");
    send(16'h0A55, 16'h1111, 16'hA5A5, 4'b1010, "R13 source group code 000");
    send(16'h8B2A, 16'h1111, 16'h4242, 4'b0101, "R13 wrong group");

    // random stream with back-pressure
    rand_ready = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ins;
      ins = op_tab[$urandom % N_OPS];
      if (ins[15:12] != 4'h8) ins = {1'($urandom), ins[14:8], 8'($urandom)};
      send(ins, 16'($urandom), 16'($urandom), 4'($urandom), tag_of(ins));
    end
    @(negedge clk);
    in_valid = 1'b0;
    rand_ready = 1'b0;
    for (int k = 0; k < 50 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all results delivered", 20'(exp_q.size()), 20'h0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired: actual %0d pending expected 0", exp_q.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule